// File: doc/BRIEF.md
# Machine CSR and Counter Unit

This block carries out the control-and-status register instructions of a single-hart, 32-bit, machine-mode-only core. The decode stage gives it a request in one cycle. The request holds the register address, the three-bit function code, the source register index (which doubles as a 5-bit immediate), the destination index and the source register value. One cycle later the block returns the register's previous value for writeback, together with a writeback enable or an illegal-instruction flag. The read-modify-write takes effect at the same clock edge.

The block holds a small machine register set:
- status, with only the interrupt-enable and previous-enable bits live
- trap vector
- scratch
- exception return address
- trap cause

It also keeps three 64-bit counters: clock cycles, a divided real-time count and retired instructions. These can only be read, through the user counter addresses. Parameters can remove the time counter and the retired counter to save area, and a removed counter reads as zero. A return-from-trap request produces a one-cycle redirect strobe that carries the saved return address to fetch, and it restores the interrupt enable.

Top module: `csr_unit`

## Requirements
- R1: Function codes (bits [1:0]): 01 writes the operand, 10 sets the operand's bits, 11 clears them. `rd_data` returns the previous value one cycle after the request, and the new value is visible to a request in the next cycle.
- R2: When function bit 2 is 1, the operand is the `req_rs1` field zero-extended to 32 bits instead of `req_src`.
- R3: Set and clear forms with `req_rs1` equal to 0 perform no write. Such a read of a read-only counter is legal.
- R4: `rd_we` is 1 one cycle after a legal request whose `req_rd` is nonzero, and it is 0 otherwise.
- R5: A request with function bits [1:0] = 00 or an address outside the implemented set raises `illegal` one cycle later. It gives `rd_data` = 0 and `rd_we` = 0, and it changes no state. The implemented set is 0x300, 0x305, 0x340, 0x341, 0x342, 0xC00–0xC02 and 0xC80–0xC82.
- R6: A request that would write an address whose bits [11:10] are 11 is illegal. This covers a write form, or a set or clear form with nonzero `req_rs1`.
- R7: The cycle counter is 64 bits wide. It is zero at reset and increments on every clock after reset. Its low half reads at 0xC00 and its high half at 0xC80. Reads return the value held before the request's edge.
- R8: The time counter increments once every TIME_DIV clocks. Its low half reads at 0xC01 and its high half at 0xC81.
- R9: The retired counter increments only on clocks where `retire` is 1. Its low half reads at 0xC02 and its high half at 0xC82.
- R10: With HAS_TIME = 0 or HAS_INSTRET = 0, the removed counter's addresses stay legal and read 0.
- R11: `mret` gives `redirect` = 1 for one cycle, one cycle later, with `redirect_pc` equal to the return-address register. At the same edge, status bit 3 takes bit 7's value and bit 7 becomes 1.
- R12: Status (0x300) reads with bits 12:11 = 11 and writable bits 3 and 7 only. The return address (0x341) reads bits 1:0 as 0.
- R13: After reset, all outputs and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register instruction present this cycle |
| req_funct | input | 3 | Function code; bit 2 selects immediate operand |
| req_addr | input | 12 | Register address |
| req_rs1 | input | 5 | Source index or immediate |
| req_rd | input | 5 | Destination index |
| req_src | input | 32 | Source register value |
| retire | input | 1 | A valid instruction leaves the last stage |
| mret | input | 1 | Return-from-trap request |
| rd_data | output | 32 | Previous register value |
| rd_we | output | 1 | Writeback enable |
| illegal | output | 1 | Illegal-instruction flag |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Redirect target |

## Verification
The assertions assume that `mret` never arrives in the same cycle as a request that writes the status register. They also assume that `rst` is high from time zero until the first clock edges have passed. The bench's random phase raises `mret` only on cycles with no request, which keeps within the first assumption. It holds reset for several cycles before driving anything, which keeps within the second. Every other combination of function code, address, index and operand is allowed, including unimplemented addresses and undefined codes.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int XLEN  = 32;
  localparam int CNT_W = 64;

  localparam logic [11:0] ADR_STATUS  = 12'h300;
  localparam logic [11:0] ADR_TVEC    = 12'h305;
  localparam logic [11:0] ADR_SCRATCH = 12'h340;
  localparam logic [11:0] ADR_EPC     = 12'h341;
  localparam logic [11:0] ADR_CAUSE   = 12'h342;
  localparam logic [11:0] ADR_CYC_LO  = 12'hC00;
  localparam logic [11:0] ADR_TIM_LO  = 12'hC01;
  localparam logic [11:0] ADR_RET_LO  = 12'hC02;
  localparam logic [11:0] ADR_CYC_HI  = 12'hC80;
  localparam logic [11:0] ADR_TIM_HI  = 12'hC81;
  localparam logic [11:0] ADR_RET_HI  = 12'hC82;

  localparam int IE_BIT  = 3;
  localparam int PIE_BIT = 7;

  typedef enum logic [1:0] {
    K_NONE  = 2'b00,
    K_WRITE = 2'b01,
    K_SET   = 2'b10,
    K_CLEAR = 2'b11
  } csr_kind_e;
endpackage

// File: rtl/csr_counters.sv
module csr_counters
  import csr_pkg::*;
#(
  parameter bit HAS_TIME    = 1'b1,
  parameter bit HAS_INSTRET = 1'b1,
  parameter int TIME_DIV    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire,
  output logic [CNT_W-1:0] cnt_cycle,
  output logic [CNT_W-1:0] cnt_time,
  output logic [CNT_W-1:0] cnt_instret
);
  localparam int DIVW = $clog2(TIME_DIV + 1);

  always_ff @(posedge clk) begin
    if (rst) cnt_cycle <= '0;
    else     cnt_cycle <= cnt_cycle + CNT_W'(1);
  end

  generate
    if (HAS_TIME) begin : g_time
      logic [DIVW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          div_q    <= '0;
          cnt_time <= '0;
        end else if (div_q == DIVW'(TIME_DIV - 1)) begin
          div_q    <= '0;
          cnt_time <= cnt_time + CNT_W'(1);
        end else begin
          div_q    <= div_q + DIVW'(1);
        end
      end
    end else begin : g_no_time
      assign cnt_time = '0;
    end

    if (HAS_INSTRET) begin : g_ret
      always_ff @(posedge clk) begin
        if (rst)         cnt_instret <= '0;
        else if (retire) cnt_instret <= cnt_instret + CNT_W'(1);
      end
    end else begin : g_no_ret
      assign cnt_instret = '0;
    end
  endgenerate
endmodule

// File: rtl/csr_mregs.sv
module csr_mregs
  import csr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [11:0]     wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            mret,
  output logic [XLEN-1:0] status_q,
  output logic [XLEN-1:0] tvec_q,
  output logic [XLEN-1:0] scratch_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] cause_q
);
  logic ie_q, pie_q;

  always_comb begin
    status_q          = '0;
    status_q[12:11]   = 2'b11;
    status_q[IE_BIT]  = ie_q;
    status_q[PIE_BIT] = pie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q      <= 1'b0;
      pie_q     <= 1'b0;
      tvec_q    <= '0;
      scratch_q <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          ADR_STATUS: begin
            ie_q  <= wr_data[IE_BIT];
            pie_q <= wr_data[PIE_BIT];
          end
          ADR_TVEC:    tvec_q    <= wr_data;
          ADR_SCRATCH: scratch_q <= wr_data;
          ADR_EPC:     epc_q     <= {wr_data[XLEN-1:2], 2'b00};
          ADR_CAUSE:   cause_q   <= wr_data;
          default: ;
        endcase
      end
      if (mret) begin
        ie_q  <= pie_q;
        pie_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter bit HAS_TIME    = 1'b1,
  parameter bit HAS_INSTRET = 1'b1,
  parameter int TIME_DIV    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [2:0]      req_funct,
  input  logic [11:0]     req_addr,
  input  logic [4:0]      req_rs1,
  input  logic [4:0]      req_rd,
  input  logic [XLEN-1:0] req_src,
  input  logic            retire,
  input  logic            mret,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_we,
  output logic            illegal,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc
);
  logic [CNT_W-1:0] cyc_cnt, tim_cnt, ret_cnt;
  logic [XLEN-1:0]  status_v, tvec_v, scratch_v, epc_v, cause_v;
  logic [XLEN-1:0]  operand, old_val, new_val;
  logic             hit, wr_intent, read_only, legal, wr_en;
  csr_kind_e        kind;

  csr_counters #(
    .HAS_TIME(HAS_TIME), .HAS_INSTRET(HAS_INSTRET), .TIME_DIV(TIME_DIV)
  ) u_cnt (
    .clk(clk), .rst(rst), .retire(retire),
    .cnt_cycle(cyc_cnt), .cnt_time(tim_cnt), .cnt_instret(ret_cnt)
  );

  csr_mregs u_mregs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(req_addr),
    .wr_data(new_val), .mret(mret),
    .status_q(status_v), .tvec_q(tvec_v), .scratch_q(scratch_v),
    .epc_q(epc_v), .cause_q(cause_v)
  );

  always_comb begin
    kind      = csr_kind_e'(req_funct[1:0]);
    operand   = req_funct[2] ? {{(XLEN-5){1'b0}}, req_rs1} : req_src;
    wr_intent = (kind == K_WRITE) || (req_rs1 != 5'd0);
    read_only = (req_addr[11:10] == 2'b11);
    hit       = 1'b1;
    case (req_addr)
      ADR_STATUS:  old_val = status_v;
      ADR_TVEC:    old_val = tvec_v;
      ADR_SCRATCH: old_val = scratch_v;
      ADR_EPC:     old_val = epc_v;
      ADR_CAUSE:   old_val = cause_v;
      ADR_CYC_LO:  old_val = cyc_cnt[XLEN-1:0];
      ADR_CYC_HI:  old_val = cyc_cnt[CNT_W-1:XLEN];
      ADR_TIM_LO:  old_val = tim_cnt[XLEN-1:0];
      ADR_TIM_HI:  old_val = tim_cnt[CNT_W-1:XLEN];
      ADR_RET_LO:  old_val = ret_cnt[XLEN-1:0];
      ADR_RET_HI:  old_val = ret_cnt[CNT_W-1:XLEN];
      default: begin
        old_val = '0;
        hit     = 1'b0;
      end
    endcase
    case (kind)
      K_WRITE: new_val = operand;
      K_SET:   new_val = old_val | operand;
      K_CLEAR: new_val = old_val & ~operand;
      default: new_val = old_val;
    endcase
    legal = req_valid && (kind != K_NONE) && hit && !(read_only && wr_intent);
    wr_en = legal && wr_intent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      rd_we       <= 1'b0;
      illegal     <= 1'b0;
      redirect    <= 1'b0;
      redirect_pc <= '0;
    end else begin
      rd_data     <= legal ? old_val : '0;
      rd_we       <= legal && (req_rd != 5'd0);
      illegal     <= req_valid && !legal;
      redirect    <= mret;
      redirect_pc <= mret ? epc_v : '0;
    end
  end
endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk
  import csr_pkg::*;
#(
  parameter bit HAS_INSTRET = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             retire,
  input logic             mret,
  input logic [XLEN-1:0]  rd_data,
  input logic             rd_we,
  input logic             illegal,
  input logic             redirect,
  input logic [XLEN-1:0]  redirect_pc,
  input logic [CNT_W-1:0] cnt_cycle,
  input logic [CNT_W-1:0] cnt_instret
);
  localparam logic [CNT_W-1:0] RET_STEP = HAS_INSTRET ? CNT_W'(1) : '0;

  assert_illegal_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (rd_data == '0) && !rd_we);

  assert_we_or_illegal_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_we, illegal}));

  assert_illegal_needs_req_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(req_valid)) |-> !illegal && !rd_we);

  assert_redirect_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (redirect == $past(mret)));

  assert_redirect_aligned_R12: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (redirect_pc[1:0] == 2'b00));

  assert_cycle_step_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt_cycle == $past(cnt_cycle) + CNT_W'(1)));

  assert_instret_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(retire)) |-> $stable(cnt_instret));

  assert_instret_step_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(retire)) |-> (cnt_instret == $past(cnt_instret) + RET_STEP));
endmodule

bind csr_unit csr_unit_chk #(.HAS_INSTRET(HAS_INSTRET)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .retire(retire), .mret(mret),
  .rd_data(rd_data), .rd_we(rd_we), .illegal(illegal), .redirect(redirect),
  .redirect_pc(redirect_pc), .cnt_cycle(cyc_cnt), .cnt_instret(ret_cnt)
);

// File: tb/csr_unit_test.sv
`timescale 1ns/1ps
module csr_unit_test;
  localparam int TDIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_funct = '0;
  logic [11:0] req_addr = '0;
  logic [4:0]  req_rs1 = '0, req_rd = '0;
  logic [31:0] req_src = '0;
  logic        retire = 1'b0, mret = 1'b0;

  logic [31:0] rd_data, redirect_pc, rd_data_m, redirect_pc_m;
  logic        rd_we, illegal, redirect, rd_we_m, illegal_m, redirect_m;

  always #5 clk = ~clk;

  csr_unit #(.HAS_TIME(1'b1), .HAS_INSTRET(1'b1), .TIME_DIV(TDIV)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_funct(req_funct),
    .req_addr(req_addr), .req_rs1(req_rs1), .req_rd(req_rd), .req_src(req_src),
    .retire(retire), .mret(mret), .rd_data(rd_data), .rd_we(rd_we),
    .illegal(illegal), .redirect(redirect), .redirect_pc(redirect_pc));

  csr_unit #(.HAS_TIME(1'b0), .HAS_INSTRET(1'b0), .TIME_DIV(TDIV)) uut_min (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_funct(req_funct),
    .req_addr(req_addr), .req_rs1(req_rs1), .req_rd(req_rd), .req_src(req_src),
    .retire(retire), .mret(mret), .rd_data(rd_data_m), .rd_we(rd_we_m),
    .illegal(illegal_m), .redirect(redirect_m), .redirect_pc(redirect_pc_m));

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R13";

  // behavioural reference state
  longint unsigned m_cyc, m_tim, m_ret;
  int          m_div;
  bit          m_ie, m_pie;
  logic [31:0] m_tvec, m_scr, m_epc, m_cause;
  logic [31:0] e_rd, e_rdm, e_pc;
  bit          e_we, e_ill, e_red;
  string       e_tag = "R13";

  function automatic bit m_hit(logic [11:0] a);
    return a inside {12'h300, 12'h305, 12'h340, 12'h341, 12'h342,
                     12'hC00, 12'hC01, 12'hC02, 12'hC80, 12'hC81, 12'hC82};
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a, bit full);
    case (a)
      12'h300: return 32'h1800 | (32'(m_pie) << 7) | (32'(m_ie) << 3);
      12'h305: return m_tvec;
      12'h340: return m_scr;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'hC00: return m_cyc[31:0];
      12'hC80: return m_cyc[63:32];
      12'hC01: return full ? m_tim[31:0] : 32'h0;
      12'hC81: return full ? m_tim[63:32] : 32'h0;
      12'hC02: return full ? m_ret[31:0] : 32'h0;
      12'hC82: return full ? m_ret[63:32] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cyc = 0; m_tim = 0; m_ret = 0; m_div = 0;
      m_ie = 0; m_pie = 0; m_tvec = 0; m_scr = 0; m_epc = 0; m_cause = 0;
      e_rd = 0; e_rdm = 0; e_pc = 0; e_we = 0; e_ill = 0; e_red = 0;
      e_tag = "R13";
    end else begin
      logic [1:0]  k;
      logic [31:0] opv, old, nv;
      bit          wi, ok;
      k   = req_funct[1:0];
      opv = req_funct[2] ? {27'b0, req_rs1} : req_src;
      wi  = (k == 2'b01) || (req_rs1 != 0);
      ok  = req_valid && (k != 2'b00) && m_hit(req_addr) &&
            !(req_addr[11:10] == 2'b11 && wi);
      old   = m_read(req_addr, 1'b1);
      e_rd  = ok ? old : 32'h0;
      e_rdm = ok ? m_read(req_addr, 1'b0) : 32'h0;
      e_we  = ok && (req_rd != 0);
      e_ill = req_valid && !ok;
      e_red = mret;
      e_pc  = mret ? m_epc : 32'h0;
      e_tag = cur_req;
      if (ok && wi) begin
        nv = (k == 2'b01) ? opv : (k == 2'b10) ? (old | opv) : (old & ~opv);
        case (req_addr)
          12'h300: begin m_ie = nv[3]; m_pie = nv[7]; end
          12'h305: m_tvec = nv;
          12'h340: m_scr = nv;
          12'h341: m_epc = {nv[31:2], 2'b00};
          12'h342: m_cause = nv;
          default: ;
        endcase
      end
      if (mret) begin m_ie = m_pie; m_pie = 1'b1; end
      m_cyc++;
      if (m_div == TDIV - 1) begin m_div = 0; m_tim++; end else m_div++;
      if (retire) m_ret++;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if ({rd_data, rd_we, illegal, redirect, redirect_pc} !==
          {e_rd, e_we, e_ill, e_red, e_pc}) begin
        fails++;
        $display("FAIL %s full: got rd=%h we=%b ill=%b red=%b pc=%h exp rd=%h we=%b ill=%b red=%b pc=%h",
                 e_tag, rd_data, rd_we, illegal, redirect, redirect_pc,
                 e_rd, e_we, e_ill, e_red, e_pc);
      end
      checks++;
      if ({rd_data_m, rd_we_m, illegal_m, redirect_m, redirect_pc_m} !==
          {e_rdm, e_we, e_ill, e_red, e_pc}) begin
        fails++;
        $display("FAIL %s/R10 reduced: got rd=%h we=%b ill=%b red=%b pc=%h exp rd=%h we=%b ill=%b red=%b pc=%h",
                 e_tag, rd_data_m, rd_we_m, illegal_m, redirect_m, redirect_pc_m,
                 e_rdm, e_we, e_ill, e_red, e_pc);
      end
    end
  end

  task automatic op(string tag, logic [2:0] f, logic [11:0] a, logic [4:0] s1,
                    logic [31:0] src, logic [4:0] rd);
    @(negedge clk);
    cur_req = tag; req_valid = 1'b1; req_funct = f; req_addr = a;
    req_rs1 = s1; req_src = src; req_rd = rd; mret = 1'b0;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur_req = tag; req_valid = 1'b0; mret = 1'b0;
    end
  endtask

  task automatic do_mret(string tag);
    @(negedge clk);
    cur_req = tag; req_valid = 1'b0; mret = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R13: outputs zero straight after reset
    checks++;
    if ({rd_data, rd_we, illegal, redirect, redirect_pc} !== '0) begin
      fails++;
      $display("FAIL R13: got %h expected 0", {rd_data, rd_we, illegal, redirect, redirect_pc});
    end
    op("R13", 3'b010, 12'h340, 5'd0, 32'h0, 5'd1);
    op("R1",  3'b001, 12'h340, 5'd4, 32'hA5A5_0F0F, 5'd1);
    op("R1",  3'b010, 12'h340, 5'd2, 32'h0000_F0F0, 5'd2);
    op("R1",  3'b011, 12'h340, 5'd3, 32'hA000_0001, 5'd3);
    op("R3",  3'b010, 12'h340, 5'd0, 32'hFFFF_FFFF, 5'd4);
    op("R3",  3'b011, 12'h340, 5'd0, 32'hFFFF_FFFF, 5'd4);
    op("R3",  3'b010, 12'h340, 5'd0, 32'h0, 5'd5);
    op("R2",  3'b101, 12'h341, 5'd31, 32'hFFFF_FFFF, 5'd6);
    op("R12", 3'b110, 12'h341, 5'd0, 32'h0, 5'd6);
    op("R2",  3'b101, 12'h305, 5'd20, 32'h0, 5'd7);
    op("R2",  3'b110, 12'h305, 5'd3, 32'h0, 5'd7);
    op("R2",  3'b111, 12'h305, 5'd16, 32'h0, 5'd7);
    op("R2",  3'b110, 12'h305, 5'd0, 32'h0, 5'd7);
    op("R4",  3'b001, 12'h342, 5'd1, 32'h8000_000B, 5'd0);
    op("R4",  3'b010, 12'h342, 5'd0, 32'h0, 5'd9);
    op("R5",  3'b001, 12'h123, 5'd1, 32'h1234, 5'd1);
    op("R5",  3'b100, 12'h340, 5'd1, 32'h5555, 5'd1);
    op("R5",  3'b000, 12'h340, 5'd1, 32'h5555, 5'd1);
    op("R5",  3'b010, 12'hC03, 5'd0, 32'h0, 5'd1);
    op("R5",  3'b010, 12'h340, 5'd0, 32'h0, 5'd1);
    op("R6",  3'b001, 12'hC00, 5'd0, 32'h0, 5'd1);
    op("R6",  3'b010, 12'hC00, 5'd1, 32'h0, 5'd1);
    op("R6",  3'b111, 12'hC02, 5'd4, 32'h0, 5'd1);
    op("R3",  3'b011, 12'hC00, 5'd0, 32'hFFFF_FFFF, 5'd1);
    op("R7",  3'b010, 12'hC00, 5'd0, 32'h0, 5'd1);
    op("R7",  3'b010, 12'hC80, 5'd0, 32'h0, 5'd1);
    for (int i = 0; i < 10; i++) begin
      op("R8", 3'b010, 12'hC01, 5'd0, 32'h0, 5'd2);
    end
    op("R8",  3'b110, 12'hC81, 5'd0, 32'h0, 5'd2);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); retire = (i % 3) != 0;
      cur_req = "R9"; req_valid = 1'b1; req_funct = 3'b010;
      req_addr = 12'hC02; req_rs1 = 0; req_rd = 5'd3;
    end
    @(negedge clk); retire = 1'b0;
    op("R9",  3'b010, 12'hC82, 5'd0, 32'h0, 5'd3);
    op("R10", 3'b010, 12'hC01, 5'd0, 32'h0, 5'd3);
    op("R10", 3'b010, 12'hC02, 5'd0, 32'h0, 5'd3);
    op("R12", 3'b001, 12'h300, 5'd1, 32'hFFFF_FFFF, 5'd1);
    op("R12", 3'b001, 12'h300, 5'd1, 32'h0000_0080, 5'd1);
    op("R11", 3'b001, 12'h341, 5'd1, 32'h0000_0402, 5'd1);
    do_mret("R11");
    idle("R11", 1);
    op("R11", 3'b010, 12'h300, 5'd0, 32'h0, 5'd1);
    do_mret("R11");
    op("R11", 3'b010, 12'h300, 5'd0, 32'h0, 5'd1);
    idle("R1", 2);
    // mixed random traffic, reference model covers every cycle
    for (int i = 0; i < 400; i++) begin
      logic [11:0] alist [13];
      alist = '{12'h300, 12'h305, 12'h340, 12'h341, 12'h342, 12'hC00, 12'hC01,
                12'hC02, 12'hC80, 12'hC81, 12'hC82, 12'h123, 12'hC03};
      @(negedge clk);
      cur_req   = "R1";
      req_valid = ($urandom % 4) != 0;
      req_funct = 3'($urandom);
      req_addr  = alist[$urandom % 13];
      req_rs1   = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
      req_rd    = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      req_src   = $urandom;
      retire    = 1'($urandom);
      mret      = !req_valid && ($urandom % 3 == 0);
    end
    @(negedge clk);
    req_valid = 1'b0; mret = 1'b0; retire = 1'b0; cur_req = "R1";
    idle("R1", 3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule